// File: doc/BRIEF.md
# Synchronous serial port controller

This block connects a processor-side register interface to a four-wire SPI-style serial bus. Software picks the role, the frame length and the options through two control words. It then writes transmit frames into an eight-entry transmit FIFO and reads received frames from an eight-entry receive FIFO. A status word shows whether there is room to write, whether there is data to read and whether a frame is on the wire.

As controller (master), the block makes the serial clock from the system clock through a fixed prescaler. It pulls chip select low for each frame, shifts data out on COPI and samples CIPO. As peripheral (slave), it synchronises the incoming clock, select and data lines into its own clock domain, receives on COPI and drives CIPO, unless its output is turned off. A loopback option feeds the transmit shifter's output straight back into the receive shifter. Frames run from 4 to 16 bits, most significant bit first. The clock idles low and data is sampled on the rising edge.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the control word (address 0) reads 0, the size word (address 1) reads 7 and the status word (address 3) reads 1. Status bit 0 is transmit-not-full, bit 1 is receive-not-empty and bit 2 is busy.
- R2: In the control word, bit 0 is loopback, bit 1 is enable, bit 2 is role (0 controller, 1 peripheral) and bit 3 is peripheral output off. Bits 31:4 of the control word and of the size word ignore writes and read 0.
- R3: A write to the role bit takes effect only if the enable bit was 0 before that write. Otherwise the role bit keeps its value.
- R4: As controller, chip select is low for exactly one frame and SCLK is low while idle. Each half period of SCLK lasts CLK_DIV system clocks, so rising edges are 2*CLK_DIV cycles apart. COPI sends the frame MSB first and is stable at each rising edge, where CIPO is sampled.
- R5: With loopback set, the receive shifter takes the transmit shifter's output, so each received frame equals the frame sent.
- R6: The size word holds the MSB index of a frame: values 3 to 15 give 4 to 16 bits, and values 0 to 2 behave as 3. Only the low bits of a transmit word are sent, and received words have their unused upper bits at 0.
- R7: Writing to the data word (address 2) pushes a frame into the transmit FIFO. Frames go out in write order, and none starts while enable is 0. Reading the data word pops the oldest received frame, and reading it while the receive FIFO is empty returns 0.
- R8: With 8 frames in the transmit FIFO, transmit-not-full is 0 and a further write is dropped.
- R9: A frame that arrives while the receive FIFO holds 8 frames is discarded, and the 8 stored frames stay readable in order.
- R10: As peripheral, the block never drives the controller outputs. While selected it shifts COPI in on rising edges, and it drives CIPO MSB first from the transmit FIFO, or sends zeros when that FIFO is empty.
- R11: When peripheral output off is set, the CIPO drive enable stays 0 while reception goes on.
- R12: Busy reads 1 while a frame is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 2) |
| reg_addr | input | 2 | Word address: 0 control, 1 size, 2 data, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| sck_o | output | 1 | Serial clock driven as controller |
| copi_o | output | 1 | Controller data out |
| cs_n_o | output | 1 | Chip select, active low, driven as controller |
| ctl_drive_o | output | 1 | Drive enable for sck_o, copi_o and cs_n_o |
| sck_i | input | 1 | Serial clock received as peripheral |
| copi_i | input | 1 | Data received as peripheral |
| cs_n_i | input | 1 | Chip select received as peripheral |
| cipo_i | input | 1 | Data received as controller |
| cipo_o | output | 1 | Peripheral data out |
| cipo_oe | output | 1 | Drive enable for cipo_o |

## Verification
In loopback, the controller is given frames of all ones, all zeros, alternating bits and single set bits at 4, 8 and 16 bits, plus an out-of-range size. These patterns expose bit order, masking and clamping errors. With loopback off, a bus model returns a different pattern from the one sent. This keeps the COPI and CIPO paths apart and measures the SCLK period. Peripheral runs compare a queued frame against an empty FIFO, and output enabled against output off. Filling both FIFOs past eight entries tests the drop and discard rules against the kept ordering.

// File: rtl/syncser_pkg.sv
package syncser_pkg;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned SIZE_W = 4;
   localparam int unsigned REG_W  = 32;

   // bit 3..0 of the control word
   typedef struct packed {
      logic sod;
      logic slave;
      logic enable;
      logic loopback;
   } ctrl_t;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_SIZE = 2'd1,
      ADDR_DATA = 2'd2,
      ADDR_STAT = 2'd3
   } addr_e;
endpackage

// File: rtl/syncser_fifo.sv
module syncser_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("fifo depth must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R8/R9: occupancy never exceeds the depth
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // R9: a push into a full store with no pop leaves it full
   a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);
endmodule

// File: rtl/syncser_sync.sv
module syncser_sync #(
   parameter int unsigned     W       = 1,
   parameter int unsigned     STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("need at least two sync stages");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stage[s-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/syncser_engine.sv
module syncser_engine
   import syncser_pkg::*;
#(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              slave,
   input  logic              lpbk,
   input  logic              sod,
   input  logic [SIZE_W-1:0] msb_idx,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_data,
   output logic              busy,
   output logic              sck_o,
   output logic              copi_o,
   output logic              cs_n_o,
   output logic              ctl_drive,
   input  logic              sck_s,
   input  logic              copi_s,
   input  logic              cs_n_s,
   input  logic              cipo_s,
   output logic              cipo_o,
   output logic              cipo_oe
);
   localparam int unsigned DIV_W = $clog2(CLK_DIV);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

   initial begin
      assert (CLK_DIV >= 2) else $error("prescaler must be at least 2");
   end

   logic              m_act, ph;
   logic [DIV_W-1:0]  cnt;
   logic [SIZE_W-1:0] bcnt;
   logic [DATA_W-1:0] txsh, rxsh, mask;
   logic              sck_d, cs_d, s_reload, s_have;
   logic              m_start, s_on, s_sel_fall, s_rise, s_fall, s_load, s_load_pop;
   logic              tx_msb, rx_bit;

   always_comb mask = DATA_W'((32'd1 << (32'(msb_idx) + 32'd1)) - 32'd1);

   assign tx_msb     = txsh[msb_idx];
   assign rx_bit     = lpbk ? tx_msb : (slave ? copi_s : cipo_s);
   assign m_start    = en && !slave && !m_act && tx_valid;
   assign s_on       = en && slave;
   assign s_sel_fall = s_on && cs_d && !cs_n_s;
   assign s_rise     = s_on && !cs_n_s && sck_s && !sck_d;
   assign s_fall     = s_on && !cs_n_s && !sck_s && sck_d;
   assign s_load     = (s_sel_fall && !s_have) || (s_fall && s_reload);
   assign s_load_pop = s_load && tx_valid;
   assign tx_pop     = m_start || s_load_pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act    <= 1'b0;
         ph       <= 1'b0;
         cnt      <= '0;
         bcnt     <= '0;
         txsh     <= '0;
         rxsh     <= '0;
         rx_push  <= 1'b0;
         rx_data  <= '0;
         sck_d    <= 1'b0;
         cs_d     <= 1'b1;
         s_reload <= 1'b0;
         s_have   <= 1'b0;
      end else begin
         sck_d   <= sck_s;
         cs_d    <= cs_n_s;
         rx_push <= 1'b0;
         if (!en) begin
            m_act    <= 1'b0;
            ph       <= 1'b0;
            cnt      <= '0;
            s_reload <= 1'b0;
            s_have   <= 1'b0;
         end else if (!slave) begin
            if (m_start) begin
               m_act <= 1'b1;
               ph    <= 1'b0;
               cnt   <= '0;
               bcnt  <= '0;
               txsh  <= tx_data;
            end else if (m_act) begin
               if (cnt == DIV_LAST) begin
                  cnt <= '0;
                  ph  <= ~ph;
                  if (!ph) begin
                     rxsh <= {rxsh[DATA_W-2:0], rx_bit};
                  end else begin
                     txsh <= txsh << 1;
                     bcnt <= bcnt + 1'b1;
                     if (bcnt == msb_idx) begin
                        m_act   <= 1'b0;
                        rx_push <= 1'b1;
                        rx_data <= rxsh & mask;
                     end
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end else begin
            if (s_sel_fall) bcnt <= '0;
            if (s_load) begin
               txsh     <= s_load_pop ? tx_data : '0;
               s_have   <= s_load_pop;
               bcnt     <= '0;
               s_reload <= 1'b0;
            end else if (s_fall) begin
               txsh <= txsh << 1;
            end
            if (s_rise) begin
               rxsh   <= {rxsh[DATA_W-2:0], rx_bit};
               s_have <= 1'b0;
               bcnt   <= bcnt + 1'b1;
               if (bcnt == msb_idx) begin
                  rx_push  <= 1'b1;
                  rx_data  <= {rxsh[DATA_W-2:0], rx_bit} & mask;
                  s_reload <= 1'b1;
               end
            end
         end
      end
   end

   assign busy      = m_act || (s_on && !cs_n_s);
   assign sck_o     = ph;
   assign copi_o    = m_act && tx_msb;
   assign cs_n_o    = !m_act;
   assign ctl_drive = en && !slave;
   assign cipo_o    = tx_msb;
   assign cipo_oe   = s_on && !sod && !cs_n_s;

   // R4: clock stays low whenever select is released
   a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sck_o);

   // R4: outgoing data does not move on a rising clock edge
   a_r4_copi_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && $rose(sck_o)) |-> $stable(copi_o));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
   import syncser_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH  = 8,
   parameter int unsigned CLK_DIV     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             sck_o,
   output logic             copi_o,
   output logic             cs_n_o,
   output logic             ctl_drive_o,
   input  logic             sck_i,
   input  logic             copi_i,
   input  logic             cs_n_i,
   input  logic             cipo_i,
   output logic             cipo_o,
   output logic             cipo_oe
);
   localparam logic [SIZE_W-1:0] SIZE_RST = SIZE_W'(7);
   localparam logic [SIZE_W-1:0] SIZE_MIN = SIZE_W'(3);

   initial begin
      assert (FIFO_DEPTH >= 2) else $error("fifo depth too small");
   end

   ctrl_t             ctrl;
   logic [SIZE_W-1:0] size_q, msb_idx;
   logic              tx_push, tx_pop, tx_empty, tx_full;
   logic              rx_push, rx_pop, rx_empty, rx_full;
   logic [DATA_W-1:0] tx_head, rx_head, rx_word;
   logic              busy;
   logic [3:0]        sync_q;
   logic              unused_wbits;

   assign unused_wbits = ^reg_wdata[REG_W-1:DATA_W] ^ rx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         size_q <= SIZE_RST;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_CTRL) begin
            ctrl.loopback <= reg_wdata[0];
            ctrl.enable   <= reg_wdata[1];
            ctrl.sod      <= reg_wdata[3];
            if (!ctrl.enable) ctrl.slave <= reg_wdata[2];
         end
         if (reg_addr == ADDR_SIZE) size_q <= reg_wdata[SIZE_W-1:0];
      end
   end

   assign msb_idx = (size_q < SIZE_MIN) ? SIZE_MIN : size_q;
   assign tx_push = reg_wr && (reg_addr == ADDR_DATA);
   assign rx_pop  = reg_rd && (reg_addr == ADDR_DATA);

   always_comb begin
      case (reg_addr)
         ADDR_CTRL: reg_rdata = {{(REG_W-4){1'b0}}, ctrl};
         ADDR_SIZE: reg_rdata = {{(REG_W-SIZE_W){1'b0}}, size_q};
         ADDR_DATA: reg_rdata = {{(REG_W-DATA_W){1'b0}}, rx_empty ? '0 : rx_head};
         default:   reg_rdata = {{(REG_W-3){1'b0}}, busy, !rx_empty, !tx_full};
      endcase
   end

   syncser_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(reg_wdata[DATA_W-1:0]),
      .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full));

   syncser_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
      .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full));

   syncser_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck_i, copi_i, cs_n_i, cipo_i}), .q(sync_q));

   syncser_engine #(.CLK_DIV(CLK_DIV)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl.enable), .slave(ctrl.slave), .lpbk(ctrl.loopback), .sod(ctrl.sod),
      .msb_idx(msb_idx),
      .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_data(rx_word), .busy(busy),
      .sck_o(sck_o), .copi_o(copi_o), .cs_n_o(cs_n_o), .ctl_drive(ctl_drive_o),
      .sck_s(sync_q[3]), .copi_s(sync_q[2]), .cs_n_s(sync_q[1]), .cipo_s(sync_q[0]),
      .cipo_o(cipo_o), .cipo_oe(cipo_oe));

   // R3: role bit cannot move in a cycle that follows an enabled cycle
   a_r3_role_locked: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl.enable) |-> (ctrl.slave == $past(ctrl.slave)));

   // R11: output-off keeps the peripheral data line released
   a_r11_sod_silent: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.sod |-> !cipo_oe);
endmodule

// File: tb/tb_sync_serial_port.sv
`timescale 1ns/1ps
module tb_sync_serial_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sck_o, copi_o, cs_n_o, ctl_drive_o, cipo_o, cipo_oe;
   logic        sck_i = 1'b0, copi_i = 1'b0, cs_n_i = 1'b1, cipo_i = 1'b0;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int unsigned cyc = 0;

   logic [15:0] exp_q[$];
   logic [15:0] pat_q[$];
   logic [15:0] cap_q[$];
   logic [15:0] mdl_cur, mdl_cap;
   int          mdl_idx = 0, mdl_bits = 8;
   int unsigned last_rise = 0, rise_gap = 0;
   bit          in_frame = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sync_serial_port dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck_o(sck_o), .copi_o(copi_o), .cs_n_o(cs_n_o), .ctl_drive_o(ctl_drive_o),
      .sck_i(sck_i), .copi_i(copi_i), .cs_n_i(cs_n_i), .cipo_i(cipo_i),
      .cipo_o(cipo_o), .cipo_oe(cipo_oe));

   // bus peripheral model for controller-mode runs
   always @(negedge cs_n_o) begin
      mdl_cur  = (pat_q.size() > 0) ? pat_q.pop_front() : 16'h0;
      mdl_idx  = mdl_bits - 1;
      cipo_i   = mdl_cur[mdl_idx];
      mdl_cap  = '0;
      in_frame = 0;
   end
   always @(posedge sck_o) if (!cs_n_o) begin
      mdl_cap = {mdl_cap[14:0], copi_o};
      if (in_frame) rise_gap = cyc - last_rise;
      last_rise = cyc;
      in_frame  = 1;
   end
   always @(negedge sck_o) if (!cs_n_o) begin
      if (mdl_idx > 0) mdl_idx--;
      cipo_i = mdl_cur[mdl_idx];
   end
   always @(posedge cs_n_o) cap_q.push_back(mdl_cap);

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // driver: push a frame and its expected receive image
   task automatic send(logic [15:0] v, logic [15:0] mask);
      wr(2'd2, {16'h0, v});
      exp_q.push_back(v & mask);
   endtask

   // monitor: pop expected items as frames become readable
   task automatic drain(string req);
      logic [31:0] s, d;
      while (exp_q.size() > 0) begin
         int tries = 0;
         do begin rd(2'd3, s); tries++; end while (!s[1] && tries < 3000);
         rd(2'd2, d);
         check(req, d, {16'h0, exp_q.pop_front()});
      end
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      int quiet = 0;
      while (quiet < 4) begin
         rd(2'd3, s);
         quiet = s[2] ? 0 : quiet + 1;
      end
      repeat (10) @(negedge clk);
   endtask

   // bench-side controller for peripheral-mode runs
   task automatic xfer(int bits, logic [15:0] v, output logic [15:0] cap, output bit oe_seen);
      cap = '0; oe_seen = 0;
      @(negedge clk); cs_n_i = 1'b0;
      repeat (10) begin @(negedge clk); if (cipo_oe) oe_seen = 1; end
      for (int i = bits - 1; i >= 0; i--) begin
         copi_i = v[i];
         repeat (8) begin @(negedge clk); if (cipo_oe) oe_seen = 1; end
         cap = {cap[14:0], cipo_o};
         sck_i = 1'b1;
         repeat (8) begin @(negedge clk); if (cipo_oe) oe_seen = 1; end
         sck_i = 1'b0;
      end
      repeat (8) @(negedge clk);
      cs_n_i = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] r, d;
      logic [15:0] cap;
      bit oe;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(2'd0, r); check("R1 ctrl", r, 32'h0);
      rd(2'd1, r); check("R1 size", r, 32'h7);
      rd(2'd3, r); check("R1 status", r, 32'h1);
      check("R1 select idle", {31'h0, cs_n_o}, 32'h1);

      // R2 reserved bits
      wr(2'd0, 32'hFFFF_FFF1); rd(2'd0, r); check("R2 ctrl reserved", r, 32'h1);
      wr(2'd1, 32'hFFFF_FF2A); rd(2'd1, r); check("R2 size reserved", r, 32'hA);
      wr(2'd0, 32'h0); wr(2'd1, 32'h7);

      // R3 role lock
      wr(2'd0, 32'h2); wr(2'd0, 32'h6); rd(2'd0, r); check("R3 locked", r, 32'h2);
      wr(2'd0, 32'h0); wr(2'd0, 32'h4); rd(2'd0, r); check("R3 free when off", r, 32'h4);
      wr(2'd0, 32'h0);

      // R5 R12 loopback, 8-bit frames
      wr(2'd0, 32'h3);
      send(16'h00A5, 16'h00FF);
      rd(2'd3, r); check("R12 busy", {31'h0, r[2]}, 32'h1);
      send(16'h003C, 16'h00FF); send(16'h00FF, 16'h00FF);
      send(16'h0000, 16'h00FF); send(16'h0081, 16'h00FF);
      drain("R5 loopback");
      wait_idle();
      rd(2'd3, r); check("R12 idle", r, 32'h1);
      rd(2'd2, r); check("R7 empty read", r, 32'h0);

      // R6 sizes and clamping
      wr(2'd1, 32'h3);
      send(16'hFFFF, 16'h000F); send(16'h0009, 16'h000F); send(16'h1236, 16'h000F);
      drain("R6 4-bit");
      wr(2'd1, 32'hF);
      send(16'hBEEF, 16'hFFFF); send(16'h8001, 16'hFFFF);
      drain("R6 16-bit");
      wr(2'd1, 32'h0);
      send(16'h00F5, 16'h000F);
      drain("R6 clamp");
      wait_idle();

      // R4 controller with external peripheral model
      wr(2'd0, 32'h0); wr(2'd1, 32'h7);
      wr(2'd0, 32'h2);
      cap_q.delete();
      mdl_bits = 8;
      pat_q.push_back(16'h0096); pat_q.push_back(16'h0011);
      send(16'h00C3, 16'h00FF); exp_q.delete(); exp_q.push_back(16'h0096);
      wr(2'd2, 32'h0070);      exp_q.push_back(16'h0011);
      drain("R4 cipo sampled");
      wait_idle();
      check("R4 frames seen", cap_q.size(), 2);
      if (cap_q.size() == 2) begin
         check("R4 copi frame0", {16'h0, cap_q[0] & 16'hFF}, 32'hC3);
         check("R4 copi frame1", {16'h0, cap_q[1] & 16'hFF}, 32'h70);
      end
      check("R4 sck period", rise_gap, 8);
      check("R4 controller drives", {31'h0, ctl_drive_o}, 32'h1);

      // R10 peripheral mode
      wr(2'd0, 32'h0); wr(2'd0, 32'h4); wr(2'd0, 32'h6);
      check("R10 no controller drive", {31'h0, ctl_drive_o}, 32'h0);
      wr(2'd2, 32'h006D);
      xfer(8, 16'h00B2, cap, oe);
      check("R10 cipo frame", {16'h0, cap}, 32'h6D);
      check("R10 cipo driven", {31'h0, oe}, 32'h1);
      rd(2'd2, r); check("R10 copi received", r, 32'hB2);
      xfer(8, 16'h005E, cap, oe);
      check("R10 empty sends zero", {16'h0, cap}, 32'h0);
      rd(2'd2, r); check("R10 second frame", r, 32'h5E);

      // R11 output off
      wr(2'd0, 32'hE);
      xfer(8, 16'h00C7, cap, oe);
      check("R11 cipo released", {31'h0, oe}, 32'h0);
      rd(2'd2, r); check("R11 still receives", r, 32'hC7);
      wr(2'd0, 32'h8); wr(2'd0, 32'h0); wr(2'd0, 32'h0);
      rd(2'd0, r); check("R3 role cleared", r, 32'h0);

      // R8 R7 transmit full while disabled
      wr(2'd1, 32'h7);
      for (int i = 1; i <= 8; i++) wr(2'd2, i);
      rd(2'd3, r); check("R8 not-full low", r, 32'h0);
      check("R7 held while off", {31'h0, cs_n_o}, 32'h1);
      wr(2'd2, 32'h9);
      for (int i = 1; i <= 8; i++) exp_q.push_back(16'(i));
      wr(2'd0, 32'h3);
      drain("R8 dropped write");
      wait_idle();
      rd(2'd3, r); check("R8 nothing extra", r, 32'h1);

      // R9 receive full discard
      for (int i = 0; i < 8; i++) send(16'h40 + 16'(i), 16'h00FF);
      wait_idle();
      wr(2'd2, 32'hEE); wr(2'd2, 32'hDD);
      wait_idle();
      drain("R9 kept order");
      rd(2'd3, r); check("R9 discarded", r, 32'h1);

      finish_run();
   end
endmodule